// File: doc/BRIEF.md
# Dual-Input Up/Down Counter with Carry and Borrow

This block is a 4-bit binary counter with two separate count inputs. A rising edge on one input steps the value up by one. A rising edge on the other input steps it down by one. An active-low load input copies a data word into the counter. A master clear forces the value to zero. Two active-low terminal outputs, carry and borrow, mark the top and bottom of the range. They are shaped so that a following stage can use them as its own count inputs.

The count inputs are treated as asynchronous. Each one passes through a synchronizer in the single system clock domain, and its rising edges are detected there. Load and clear are system-domain controls. They take effect on the next system clock edge, whatever the count inputs are doing. Any count edge detected while load or clear is active is discarded. It is not carried over to a later cycle.

If edges on both count inputs are detected in the same cycle, the value is held and a sticky error flag is raised. The flag stays set until a system reset or a clear.

Top module: `dual_step_counter`

## Requirements
- R1: After `rst` the outputs are `count`=0, `carry_n`=1, `borrow_n`=1 and `clash_err`=0.
- R2: Each rising edge of `up_in` raises `count` by exactly one.
- R3: Each rising edge of `dn_in` lowers `count` by exactly one.
- R4: Counting wraps modulo 16. Stepping up from 15 gives 0, and stepping down from 0 gives 15.
- R5: While `load_n` is 0, each clock copies `din` into `count`. A count edge detected during this time is ignored and is not applied later.
- R6: While `clear` is 1, `count` goes to 0 and `clash_err` goes to 0. This overrides `load_n` and both count inputs.
- R7: `carry_n` is 0 exactly when `count` is 15 and the synchronized `up_in` is low. At any other count it stays 1, even with `up_in` low.
- R8: `borrow_n` is 0 exactly when `count` is 0 and the synchronized `dn_in` is low.
- R9: If rising edges of both count inputs are detected in the same cycle, `count` is unchanged and `clash_err` becomes 1. It stays 1 through later steps until `rst` or `clear`.
- R10: A count input that rises just before a clock edge changes `count` on the third rising clock edge, counting that edge as the first. It does not change it on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| up_in | input | 1 | Asynchronous count-up input, idle high |
| dn_in | input | 1 | Asynchronous count-down input, idle high |
| load_n | input | 1 | Active-low parallel load |
| din | input | 4 | Parallel load data |
| clear | input | 1 | Active-high master clear |
| count | output | 4 | Counter value |
| carry_n | output | 1 | Active-low terminal count at the top of the range |
| borrow_n | output | 1 | Active-low terminal count at the bottom of the range |
| clash_err | output | 1 | Sticky flag for coincident up and down edges |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a count edge together with load or clear. The bench raises `up_in` on the same cycle that `load_n` falls, or that `clear` rises, and holds the control long enough for the edge to reach the detector. It then expects the loaded value or zero, with no extra step afterwards.

The second pair is an up edge together with a down edge. The bench drops and raises both count inputs on the same cycles. It expects the value to hold and the error flag to be set. A following up step must then move the count while the flag stays set.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_UP,
    ACT_DOWN,
    ACT_LOAD,
    ACT_CLEAR,
    ACT_CLASH
  } dsc_act_e;
endpackage

// File: rtl/dsc_edge_sync.sv
module dsc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sr;
  logic              prev;

  // Idle level of the count inputs is high, so reset to 1 to avoid a false edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '1;
      prev <= 1'b1;
    end else begin
      sr   <= {sr[STAGES-2:0], async_in};
      prev <= sr[STAGES-1];
    end
  end

  assign level = sr[STAGES-1];
  assign rise  = sr[STAGES-1] & ~prev;

  // R10: one step per input edge; the detector pulses for a single cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/dsc_step_core.sv
module dsc_step_core
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             up_rise,
  input  logic             dn_rise,
  output logic [WIDTH-1:0] count,
  output logic             err
);
  dsc_act_e act;

  always_comb begin
    if (clear)                   act = ACT_CLEAR;
    else if (!load_n)            act = ACT_LOAD;
    else if (up_rise && dn_rise) act = ACT_CLASH;
    else if (up_rise)            act = ACT_UP;
    else if (dn_rise)            act = ACT_DOWN;
    else                         act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      err   <= 1'b0;
    end else begin
      case (act)
        ACT_CLEAR: begin count <= '0; err <= 1'b0; end
        ACT_LOAD:  count <= din;
        ACT_UP:    count <= count + 1'b1;
        ACT_DOWN:  count <= count - 1'b1;
        ACT_CLASH: err   <= 1'b1;
        default:   count <= count;
      endcase
    end
  end

  a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
    (up_rise && !dn_rise && !clear && load_n) |=> count == WIDTH'($past(count) + 1'b1));
  a_r3_down_step: assert property (@(posedge clk) disable iff (rst)
    (dn_rise && !up_rise && !clear && load_n) |=> count == WIDTH'($past(count) - 1'b1));
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load_n) |=> count == $past(din));
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0 && !err));
  a_r9_clash_hold: assert property (@(posedge clk) disable iff (rst)
    (up_rise && dn_rise && !clear && load_n) |=> (count == $past(count) && err));
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && !clear) |=> err);
endmodule

// File: rtl/dsc_term_detect.sv
module dsc_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  always_comb begin
    carry_n  = ~((count == TOP) & ~up_lvl);
    borrow_n = ~((count == '0) & ~dn_lvl);
  end

  // R7 / R8: the strobes can only appear at the matching end of the range
  always_comb begin
    a_r7_carry_at_top: assert (carry_n || count == TOP);
    a_r8_borrow_at_zero: assert (borrow_n || count == '0);
  end
endmodule

// File: rtl/dual_step_counter.sv
module dual_step_counter #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_in,
  input  logic             dn_in,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             clear,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n,
  output logic             clash_err
);
  localparam int NCH = 2; // channel 0 counts up, channel 1 counts down

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] lvl;
  logic [NCH-1:0] rise;

  assign raw_in = {dn_in, up_in};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_sync
    dsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (raw_in[ch]),
      .level    (lvl[ch]),
      .rise     (rise[ch])
    );
  end

  dsc_step_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .load_n  (load_n),
    .din     (din),
    .up_rise (rise[0]),
    .dn_rise (rise[1]),
    .count   (count),
    .err     (clash_err)
  );

  dsc_term_detect #(.WIDTH(WIDTH)) u_term (
    .count    (count),
    .up_lvl   (lvl[0]),
    .dn_lvl   (lvl[1]),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

  // R1: clean state right after system reset
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (count == '0 && carry_n && borrow_n && !clash_err));
endmodule

// File: tb/sim_dual_step_counter.sv
module sim_dual_step_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up_in = 1'b1, dn_in = 1'b1, load_n = 1'b1, clear = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] count;
  logic       carry_n, borrow_n, clash_err;

  always #5 clk = ~clk;

  dual_step_counter u0 (
    .clk(clk), .rst(rst), .up_in(up_in), .dn_in(dn_in), .load_n(load_n),
    .din(din), .clear(clear), .count(count), .carry_n(carry_n),
    .borrow_n(borrow_n), .clash_err(clash_err)
  );

  typedef struct {
    logic [3:0] cnt;
    logic       cy;
    logic       bw;
    logic       er;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  task automatic push(input logic [3:0] c, input logic cy, input logic bw,
                      input logic er, input string tag);
    exp_t e;
    e.cnt = c; e.cy = cy; e.bw = bw; e.er = er; e.tag = tag;
    q.push_back(e);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_now(input logic [3:0] c, input string tag);
    n_chk++;
    if (count !== c) begin
      n_bad++;
      $display("FAIL %s: count=%0d expected %0d", tag, count, c);
    end
  endtask

  task automatic set_up(input logic v);
    up_in = v; repeat (5) @(negedge clk);
  endtask
  task automatic set_dn(input logic v);
    dn_in = v; repeat (5) @(negedge clk);
  endtask
  task automatic do_load(input logic [3:0] v);
    din = v; load_n = 1'b0; @(negedge clk); load_n = 1'b1; repeat (3) @(negedge clk);
  endtask

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (count !== e.cnt || carry_n !== e.cy || borrow_n !== e.bw || clash_err !== e.er) begin
          n_bad++;
          $display("FAIL %s: got cnt=%0d cy=%b bw=%b er=%b expected cnt=%0d cy=%b bw=%b er=%b",
                   e.tag, count, carry_n, borrow_n, clash_err, e.cnt, e.cy, e.bw, e.er);
        end
      end
    end
  end

  // driver
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    push(4'd0, 1, 1, 0, "R1 reset state");

    // R10 latency, then R2 counting up
    up_in = 1'b0; repeat (5) @(negedge clk);
    up_in = 1'b1;
    repeat (2) @(negedge clk);
    check_now(4'd0, "R10 no change after two edges");
    @(negedge clk);
    check_now(4'd1, "R10 step on third edge");
    repeat (3) @(negedge clk);
    push(4'd1, 1, 1, 0, "R2 first up step");
    set_up(0); set_up(1);
    push(4'd2, 1, 1, 0, "R2 second up step");

    // R3 counting down
    set_dn(0); set_dn(1);
    push(4'd1, 1, 1, 0, "R3 down step");

    // R7 low up input away from the top keeps carry high
    set_up(0);
    push(4'd1, 1, 1, 0, "R7 carry high below top");
    set_up(1);
    push(4'd2, 1, 1, 0, "R2 step after carry probe");

    // R5 load, then R7 carry and R4 wrap up
    do_load(4'd15);
    push(4'd15, 1, 1, 0, "R5 load of 15");
    set_up(0);
    push(4'd15, 0, 1, 0, "R7 carry low at 15");
    set_up(1);
    push(4'd0, 1, 1, 0, "R4 wrap 15 to 0");

    // R8 borrow and R4 wrap down
    set_dn(0);
    push(4'd0, 1, 0, 0, "R8 borrow low at 0");
    set_dn(1);
    push(4'd15, 1, 1, 0, "R4 wrap 0 to 15");

    // R5 load coinciding with an up edge: edge discarded
    set_up(0);
    din = 4'd9; load_n = 1'b0; up_in = 1'b1;
    repeat (5) @(negedge clk);
    load_n = 1'b1; repeat (4) @(negedge clk);
    push(4'd9, 1, 1, 0, "R5 load wins over edge");

    // R9 both edges in the same cycle
    up_in = 1'b0; dn_in = 1'b0; repeat (5) @(negedge clk);
    up_in = 1'b1; dn_in = 1'b1; repeat (5) @(negedge clk);
    push(4'd9, 1, 1, 1, "R9 clash holds and flags");
    set_up(0); set_up(1);
    push(4'd10, 1, 1, 1, "R9 flag sticky across step");

    // R6 clear overrides load and an up edge
    set_up(0);
    clear = 1'b1; load_n = 1'b0; din = 4'd5; up_in = 1'b1;
    repeat (5) @(negedge clk);
    clear = 1'b0; load_n = 1'b1; repeat (4) @(negedge clk);
    push(4'd0, 1, 1, 0, "R6 clear overrides all");

    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected done");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule